// File: doc/BRIEF.md
# Display Channel Error and Interrupt Monitor

This block watches one output channel of a display compositor. The channel writes pixels into a display FIFO, and a downstream timing engine drains that FIFO. The monitor follows the channel's operating mode and records a set of sticky error and progress events: frame completion, completion of one programmed line, a short line, a short frame, a FIFO underflow and bus response errors. It counts frames and lines, and it combines the enabled events into a channel interrupt and a DMA interrupt.

Software reaches the block through a small register port with four word addresses. Reads are combinational from the address. Writes take effect at the next clock edge. The status word reports the sticky events, the last bus response code, the live FIFO flags, the mode, the frame count and the current line number. A single write with bit 0 set clears every sticky event.

Top module: `disp_chan_monitor`

## Requirements
- R1: After reset, every register readback is zero and irq_o and dma_irq_o are low. This includes the status word when the FIFO flag inputs are low.
- R2: The mode field (status bits 12:11) shows the value of chan_mode_i one clock after that value is applied. The mode encoding is 0 = disabled, 1 = init, 2 = run, 3 = end-of-frame.
- R3: The end-of-frame event (status bit 0) is set only when the mode moves from run (2) to end-of-frame (3). No other mode pair sets it.
- R4: The 6-bit frame counter (status bits 18:13) increments once on every move from run to end-of-frame. It wraps from 63 to 0.
- R5: A horizontal-start strobe sets the short-line event (status bit 2) if pixels of the current line are still pending. The same strobe with no pixels pending has no effect.
- R6: A vertical-start strobe sets the short-frame event (status bit 3) if pixels of the current line are still pending. The same strobe with no pixels pending has no effect.
- R7: A FIFO read while the FIFO is empty sets the underflow event (status bit 4). A read from a non-empty FIFO does not set it. The live empty and full flags appear at status bits 9 and 10.
- R8: The 12-bit line counter (status bits 30:19) returns to 0 on vertical start and otherwise increments on each line-done strobe. The line event (status bit 1) is set when a line-done strobe arrives while the counter equals the target held at address 2.
- R9: Each valid bus response stores its 2-bit code (0 OKAY, 1 EXOKAY, 2 SLVERR, 3 DECERR) in status bits 7:6. A non-OKAY code, or an invalid-ID strobe, sets the DMA event (status bit 5). dma_irq_o equals the DMA event ANDed with control bit 4.
- R10: irq_o is high only when control bit 0 (master enable) is set and at least one of these holds: the end-of-frame event with control bit 1; the line event with control bit 2; the short-line or underflow event with control bit 3; the short-frame event, which needs no enable of its own. status bit 8 mirrors irq_o.
- R11: A write to the status address (1) with bit 0 set clears all six events. If an event occurs in the same cycle as that write, the new event stays set. A write to that address with bit 0 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_mode_i | input | 2 | Channel mode from the compositor |
| hstart_i | input | 1 | Horizontal-start strobe from the timing engine |
| vstart_i | input | 1 | Vertical-start strobe from the timing engine |
| pix_pending_i | input | 1 | Pixels of the current output line are still outstanding |
| line_done_i | input | 1 | The current line has finished compositing |
| fifo_rd_i | input | 1 | Downstream read of the display FIFO |
| fifo_empty_i | input | 1 | Display FIFO empty |
| fifo_full_i | input | 1 | Display FIFO full |
| resp_valid_i | input | 1 | Bus response code is valid |
| resp_i | input | 2 | Bus response code |
| bad_id_i | input | 1 | Invalid DMA ID strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address: 0 control, 1 status, 2 line target |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Channel interrupt |
| dma_irq_o | output | 1 | DMA interrupt |

## Verification
A wrong internal state in this block shows up at the ports within one clock, because every register feeds the status readback and the interrupt outputs directly.
- A mode register that fails to track its input hides a run-to-end-of-frame edge. That appears at once as a frame count that is one low, with the end-of-frame bit missing.
- A line counter that drifts moves the line event to the wrong strobe, and the line field shows the drift.
- A sticky bit that decays, or clears incorrectly, changes irq_o in the cycle after the fault.

The bench sweeps all sixteen mode pairs and all 32 control values against each event source. It also drives the frame counter through its wrap.

// File: rtl/dcm_pkg.sv
// Shared constants for the display channel monitor.
// Assumes a 2-bit mode code and a fixed six-event status vector.
package dcm_pkg;
    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_INIT = 2'd1;
    localparam logic [1:0] MODE_RUN  = 2'd2;
    localparam logic [1:0] MODE_EOF  = 2'd3;

    // event indices inside the sticky vector (also status bit positions)
    localparam int EV_EOF    = 0;
    localparam int EV_EOLN   = 1;
    localparam int EV_SLINE  = 2;
    localparam int EV_SFRAME = 3;
    localparam int EV_UFLOW  = 4;
    localparam int EV_DMA    = 5;
    localparam int NUM_EV    = 6;

    // control register bits
    localparam int C_MASTER = 0;
    localparam int C_EOF    = 1;
    localparam int C_EOLN   = 2;
    localparam int C_SLINE  = 3;
    localparam int C_DMA    = 4;
    localparam int CTRL_W   = 5;

    // register word addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STAT   = 2'd1;
    localparam logic [1:0] ADDR_TARGET = 2'd2;

    // status word layout
    localparam int ST_RESP_LSB  = 6;
    localparam int ST_IRQ       = 8;
    localparam int ST_EMPTY     = 9;
    localparam int ST_FULL      = 10;
    localparam int ST_MODE_LSB  = 11;
    localparam int ST_FRAME_LSB = 13;
endpackage

// File: rtl/dcm_event_detect.sv
// Event detector: registers the channel mode and turns the input strobes
// into single-cycle event pulses, one per sticky status bit.
// Assumes all strobes are synchronous to clk and one cycle wide.
module dcm_event_detect
    import dcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              hstart_i,
    input  logic              vstart_i,
    input  logic              pend_i,
    input  logic              line_done_i,
    input  logic              line_hit_i,
    input  logic              fifo_rd_i,
    input  logic              fifo_empty_i,
    input  logic              resp_valid_i,
    input  logic [1:0]        resp_i,
    input  logic              bad_id_i,
    output logic [1:0]        mode_q,
    output logic              run_to_eof_o,
    output logic [NUM_EV-1:0] ev_o
);
    // Hold the last seen mode so that transitions can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_i;
    end

    // Transition from run to end-of-frame, seen at the input this cycle.
    assign run_to_eof_o = (mode_q == MODE_RUN) && (mode_i == MODE_EOF);

    // Build the event pulse vector.
    always_comb begin
        ev_o            = '0;
        ev_o[EV_EOF]    = run_to_eof_o;
        ev_o[EV_EOLN]   = line_done_i && line_hit_i && !vstart_i;
        ev_o[EV_SLINE]  = hstart_i && pend_i;
        ev_o[EV_SFRAME] = vstart_i && pend_i;
        ev_o[EV_UFLOW]  = fifo_rd_i && fifo_empty_i;
        ev_o[EV_DMA]    = (resp_valid_i && (resp_i != 2'd0)) || bad_id_i;
    end
endmodule

// File: rtl/dcm_counters.sv
// Line and frame counters. The line counter restarts at vertical start and
// advances on line-done; the frame counter advances on each frame end and wraps.
module dcm_counters #(
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vstart_i,
    input  logic               line_done_i,
    input  logic               frame_tick_i,
    input  logic [LINE_W-1:0]  target_i,
    output logic [LINE_W-1:0]  line_cnt_o,
    output logic [FRAME_W-1:0] frame_cnt_o,
    output logic               line_hit_o
);
    // Line counter: vertical start has priority over line-done.
    always_ff @(posedge clk) begin
        if (!rst_n)           line_cnt_o <= '0;
        else if (vstart_i)    line_cnt_o <= '0;
        else if (line_done_i) line_cnt_o <= line_cnt_o + 1'b1;
    end

    // Frame counter: modulo 2**FRAME_W.
    always_ff @(posedge clk) begin
        if (!rst_n)            frame_cnt_o <= '0;
        else if (frame_tick_i) frame_cnt_o <= frame_cnt_o + 1'b1;
    end

    assign line_hit_o = (line_cnt_o == target_i);
endmodule

// File: rtl/dcm_sticky_bank.sv
// Bank of sticky status bits with a shared clear; a set in the same cycle
// as the clear wins. One flop per event, built with generate.
module dcm_sticky_bank #(
    parameter int NUM = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic           clr_all_i,
    output logic [NUM-1:0] sticky_o
);
    for (genvar k = 0; k < NUM; k++) begin : g_bit
        // Set dominates clear; otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         sticky_o[k] <= 1'b0;
            else if (set_i[k])  sticky_o[k] <= 1'b1;
            else if (clr_all_i) sticky_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/disp_chan_monitor.sv
// Display channel error and interrupt monitor (top).
// Holds the control, line-target and response registers, serves the register
// port and forms the two interrupts from the sticky events.
// Assumes reads are combinational from reg_addr_i and writes take one edge.
module disp_chan_monitor
    import dcm_pkg::*;
#(
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 6,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode_i,
    input  logic              hstart_i,
    input  logic              vstart_i,
    input  logic              pix_pending_i,
    input  logic              line_done_i,
    input  logic              fifo_rd_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_full_i,
    input  logic              resp_valid_i,
    input  logic [1:0]        resp_i,
    input  logic              bad_id_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              dma_irq_o
);
    localparam int ST_LINE_LSB = ST_FRAME_LSB + FRAME_W;

    logic [1:0]         mode_q;
    logic               run_to_eof;
    logic [NUM_EV-1:0]  ev;
    logic [NUM_EV-1:0]  sticky;
    logic               clr_all;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [LINE_W-1:0]  target_q;
    logic [1:0]         resp_q;
    logic [LINE_W-1:0]  line_cnt;
    logic [FRAME_W-1:0] frame_cnt;
    logic               line_hit;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:LINE_W];
    assign clr_all = reg_wr_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

    dcm_event_detect u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (chan_mode_i),
        .hstart_i     (hstart_i),
        .vstart_i     (vstart_i),
        .pend_i       (pix_pending_i),
        .line_done_i  (line_done_i),
        .line_hit_i   (line_hit),
        .fifo_rd_i    (fifo_rd_i),
        .fifo_empty_i (fifo_empty_i),
        .resp_valid_i (resp_valid_i),
        .resp_i       (resp_i),
        .bad_id_i     (bad_id_i),
        .mode_q       (mode_q),
        .run_to_eof_o (run_to_eof),
        .ev_o         (ev)
    );

    dcm_counters #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .vstart_i     (vstart_i),
        .line_done_i  (line_done_i),
        .frame_tick_i (run_to_eof),
        .target_i     (target_q),
        .line_cnt_o   (line_cnt),
        .frame_cnt_o  (frame_cnt),
        .line_hit_o   (line_hit)
    );

    dcm_sticky_bank #(.NUM(NUM_EV)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ev),
        .clr_all_i (clr_all),
        .sticky_o  (sticky)
    );

    // Software-written control and line-target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            target_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == ADDR_CTRL)   ctrl_q   <= reg_wdata_i[CTRL_W-1:0];
            if (reg_addr_i == ADDR_TARGET) target_q <= reg_wdata_i[LINE_W-1:0];
        end
    end

    // Capture the most recent bus response code.
    always_ff @(posedge clk) begin
        if (!rst_n)            resp_q <= 2'd0;
        else if (resp_valid_i) resp_q <= resp_i;
    end

    // Combine enabled events into the channel and DMA interrupts.
    always_comb begin
        irq_o = ctrl_q[C_MASTER] &
                ((sticky[EV_EOF]  & ctrl_q[C_EOF])  |
                 (sticky[EV_EOLN] & ctrl_q[C_EOLN]) |
                 ((sticky[EV_SLINE] | sticky[EV_UFLOW]) & ctrl_q[C_SLINE]) |
                 sticky[EV_SFRAME]);
        dma_irq_o = sticky[EV_DMA] & ctrl_q[C_DMA];
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTRL:   reg_rdata_o[CTRL_W-1:0] = ctrl_q;
            ADDR_STAT: begin
                reg_rdata_o[NUM_EV-1:0]              = sticky;
                reg_rdata_o[ST_RESP_LSB +: 2]        = resp_q;
                reg_rdata_o[ST_IRQ]                  = irq_o;
                reg_rdata_o[ST_EMPTY]                = fifo_empty_i;
                reg_rdata_o[ST_FULL]                 = fifo_full_i;
                reg_rdata_o[ST_MODE_LSB +: 2]        = mode_q;
                reg_rdata_o[ST_FRAME_LSB +: FRAME_W] = frame_cnt;
                reg_rdata_o[ST_LINE_LSB +: LINE_W]   = line_cnt;
            end
            ADDR_TARGET: reg_rdata_o[LINE_W-1:0] = target_q;
            default:     reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dcm_checker.sv
// Assertion checker for disp_chan_monitor, attached with bind below.
// Relates the mode input, sticky state, counters and interrupt over time.
module dcm_checker
    import dcm_pkg::*;
#(
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         chan_mode_i,
    input logic [1:0]         mode_q,
    input logic               vstart_i,
    input logic               clr_all,
    input logic [NUM_EV-1:0]  ev,
    input logic [NUM_EV-1:0]  sticky,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic [LINE_W-1:0]  line_cnt,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic               irq_o
);
    logic frame_edge;
    assign frame_edge = (mode_q == MODE_RUN) && (chan_mode_i == MODE_EOF);

    // R2: the registered mode follows the input one cycle later
    p_mode_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_q == $past(chan_mode_i));

    // R3: the run to end-of-frame move sets the frame-end event
    p_eof_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> sticky[EV_EOF]);

    // R4: the frame counter steps by one on a frame end
    p_frame_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1));

    // R4: the frame counter holds when there is no frame end
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_edge |=> $stable(frame_cnt));

    // R8: vertical start returns the line counter to zero
    p_line_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_i |=> line_cnt == '0);

    // R11: without a clear, no sticky bit falls
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> (sticky & $past(sticky)) == $past(sticky));

    // R11: a clear with no new event empties the bank
    p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && ev == '0) |=> sticky == '0);

    // R10: the short-frame event raises the interrupt under the master enable
    p_sframe_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky[EV_SFRAME] && ctrl_q[C_MASTER]) |-> irq_o);

    // R10: no interrupt without the master enable
    p_irq_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[C_MASTER] |-> !irq_o);
endmodule

bind disp_chan_monitor dcm_checker #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_dcm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_mode_i (chan_mode_i),
    .mode_q      (mode_q),
    .vstart_i    (vstart_i),
    .clr_all     (clr_all),
    .ev          (ev),
    .sticky      (sticky),
    .frame_cnt   (frame_cnt),
    .line_cnt    (line_cnt),
    .ctrl_q      (ctrl_q),
    .irq_o       (irq_o)
);

// File: tb/disp_chan_monitor_tb_top.sv
// Self-checking bench for disp_chan_monitor: sweeps mode pairs, control
// values and event sources, computing expectations arithmetically.
module disp_chan_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  chan_mode = 2'd0;
    logic        hstart = 0, vstart = 0, pend = 0, line_done = 0;
    logic        fifo_rd = 0, fifo_empty = 0, fifo_full = 0;
    logic        resp_valid = 0, bad_id = 0;
    logic [1:0]  resp = 2'd0;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dma_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int exp_frame = 0;
    logic [1:0] cur_mode = 2'd0;

    always #10 clk = ~clk;   // 50 MHz

    disp_chan_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .chan_mode_i(chan_mode),
        .hstart_i(hstart), .vstart_i(vstart), .pix_pending_i(pend),
        .line_done_i(line_done), .fifo_rd_i(fifo_rd), .fifo_empty_i(fifo_empty),
        .fifo_full_i(fifo_full), .resp_valid_i(resp_valid), .resp_i(resp),
        .bad_id_i(bad_id), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
        .dma_irq_o(dma_irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        if (cur_mode == 2'd2 && m == 2'd3) exp_frame++;
        cur_mode = m;
        chan_mode = m;
    endtask

    task automatic clear_all();
        wr(2'd1, 32'h1);
    endtask

    function automatic logic [31:0] evbits(input logic [31:0] s);
        return {26'd0, s[5:0]};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        @(negedge clk);
        repeat (4) step();
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd1, s); check("R1 status", s, 32'd0);
        rd(2'd0, s); check("R1 ctrl", s, 32'd0);
        rd(2'd2, s); check("R1 target", s, 32'd0);
        check("R1 irq", {30'd0, irq, dma_irq}, 32'd0);

        // R4: frame counter through its wrap
        for (int i = 0; i < 65; i++) begin
            set_mode(2'd2); step();
            set_mode(2'd3); step();
            if (i == 62) begin rd(2'd1, s); check("R4 frame 63", s[18:13], 32'd63); end
            if (i == 63) begin rd(2'd1, s); check("R4 frame wrap", s[18:13], 32'd0); end
        end
        rd(2'd1, s); check("R4 frame after wrap", s[18:13], 32'(exp_frame % 64));

        // R2 R3: all mode pairs
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                set_mode(2'(p)); step();
                clear_all();
                set_mode(2'(n)); step();
                rd(2'd1, s);
                check("R3 eof per mode pair", s[0], 32'((p == 2 && n == 3) ? 1 : 0));
                check("R2 mode field", s[12:11], 32'(n));
            end
        end
        rd(2'd1, s); check("R4 frame after sweep", s[18:13], 32'(exp_frame % 64));
        set_mode(2'd0); step();

        // R5: short line
        clear_all();
        hstart = 1; pend = 0; step(); hstart = 0;
        rd(2'd1, s); check("R5 hstart no pending", evbits(s), 32'd0);
        hstart = 1; pend = 1; step(); hstart = 0; pend = 0;
        rd(2'd1, s); check("R5 hstart pending", evbits(s), 32'h04);

        // R6: short frame
        clear_all();
        vstart = 1; pend = 0; step(); vstart = 0;
        rd(2'd1, s); check("R6 vstart no pending", evbits(s), 32'd0);
        vstart = 1; pend = 1; step(); vstart = 0; pend = 0;
        rd(2'd1, s); check("R6 vstart pending", evbits(s), 32'h08);

        // R7: underflow and live FIFO flags
        clear_all();
        fifo_rd = 1; fifo_empty = 0; step(); fifo_rd = 0;
        rd(2'd1, s); check("R7 read non-empty", evbits(s), 32'd0);
        fifo_rd = 1; fifo_empty = 1; step(); fifo_rd = 0;
        rd(2'd1, s); check("R7 read empty", evbits(s), 32'h10);
        check("R7 empty flag", s[9], 32'd1);
        fifo_empty = 0; fifo_full = 1;
        rd(2'd1, s); check("R7 full flag", {30'd0, s[10:9]}, 32'd2);
        fifo_full = 0;

        // R8: line counter and programmed-line event
        clear_all();
        wr(2'd2, 32'd3);
        rd(2'd2, s); check("R8 target readback", s, 32'd3);
        vstart = 1; step(); vstart = 0;
        rd(2'd1, s); check("R8 line after vstart", s[30:19], 32'd0);
        for (int k = 1; k <= 4; k++) begin
            line_done = 1; step(); line_done = 0;
            rd(2'd1, s);
            check("R8 line count", s[30:19], 32'(k));
            check("R8 line event", s[1], 32'((k == 4) ? 1 : 0));
        end
        vstart = 1; line_done = 1; step(); vstart = 0; line_done = 0;
        rd(2'd1, s); check("R8 vstart beats line-done", s[30:19], 32'd0);

        // R9: bus responses
        clear_all();
        wr(2'd0, 32'h10);
        resp_valid = 1; resp = 2'd0; step(); resp_valid = 0;
        rd(2'd1, s); check("R9 okay no dma", {s[7:6], s[5]}, 32'd0);
        check("R9 dma irq low", dma_irq, 32'd0);
        for (int c = 1; c < 4; c++) begin
            clear_all();
            resp_valid = 1; resp = 2'(c); step(); resp_valid = 0;
            rd(2'd1, s);
            check("R9 resp code", s[7:6], 32'(c));
            check("R9 dma event", evbits(s), 32'h20);
            check("R9 dma irq", dma_irq, 32'd1);
        end
        clear_all();
        resp_valid = 1; resp = 2'd0; step(); resp_valid = 0;
        bad_id = 1; step(); bad_id = 0;
        rd(2'd1, s); check("R9 bad id", {s[7:6], s[5:0]}, 32'h20);
        wr(2'd0, 32'h0f);
        check("R9 dma irq masked", dma_irq, 32'd0);
        clear_all();

        // R10: enable masking, one event source at a time
        for (int src = 0; src < 5; src++) begin
            wr(2'd0, 32'd0);
            clear_all();
            case (src)
                0: begin set_mode(2'd2); step(); set_mode(2'd3); step(); set_mode(2'd0); step(); end
                1: begin wr(2'd2, 32'd0); vstart = 1; step(); vstart = 0;
                         line_done = 1; step(); line_done = 0; end
                2: begin hstart = 1; pend = 1; step(); hstart = 0; pend = 0; end
                3: begin vstart = 1; pend = 1; step(); vstart = 0; pend = 0; end
                default: begin fifo_rd = 1; fifo_empty = 1; step(); fifo_rd = 0; fifo_empty = 0; end
            endcase
            for (int c = 0; c < 32; c++) begin
                logic e;
                wr(2'd0, 32'(c));
                case (src)
                    0: e = c[0] & c[1];
                    1: e = c[0] & c[2];
                    2: e = c[0] & c[3];
                    3: e = c[0];
                    default: e = c[0] & c[3];
                endcase
                rd(2'd1, s);
                check("R10 irq per enable", {31'd0, irq}, 32'(e));
                check("R10 status irq bit", s[8], 32'(e));
            end
        end
        rd(2'd0, s); check("R10 ctrl readback", s, 32'd31);

        // R11: clear-all, event wins, bit0-clear write ignored
        clear_all();
        fifo_rd = 1; fifo_empty = 1; step(); fifo_rd = 0; fifo_empty = 0;
        hstart = 1; pend = 1; wr(2'd1, 32'h1); hstart = 0; pend = 0;
        rd(2'd1, s); check("R11 event wins over clear", evbits(s), 32'h04);
        wr(2'd1, 32'h3e);
        rd(2'd1, s); check("R11 bit0 clear ignored", evbits(s), 32'h04);
        clear_all();
        rd(2'd1, s); check("R11 clear all", evbits(s), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule